// File: doc/BRIEF.md
# Dual-Bank Read-While-Write Controller

This block is the control core of a two-bank nonvolatile memory model. The word array is split into a small boot bank and a larger main bank. The host can read from one bank while a program or erase runs in the other. The block decodes the bank from the top address bits. The number of those bits is a parameter, so the boot bank can be one half, one quarter or one eighth of the space. Each bank keeps its own busy state, embedded-operation kind, erase-suspend flag and status toggle bit.

An outer command layer decodes host write sequences. It raises `cmd_go` with an opcode once a command is complete, using the current host address and `cmd_wdata`. An operation timer for each bank pulses `op_done` when that bank's program or erase has run its course. Reads are combinational. While a read is asserted, `rd_data` shows either array data or a status word, and the choice depends only on the state of the addressed bank. All host and command pins are plain level and strobe signals, sampled on the rising clock edge. There is no valid/ready handshake, because the memory model never applies back-pressure.

Top module: `rww_ctrl`

## Requirements
- R1: An address whose top `BANK_BITS` bits are all ones belongs to the boot bank (index 0), which has sectors of `SMALL_WORDS` words. Every other address belongs to the main bank (index 1), which has sectors of `LARGE_WORDS` words.
- R2: A read (`host_ce`=1, `host_oe`=1, `host_we`=0) to a bank with no embedded operation returns the array word at that address in the same cycle, even while the other bank is busy. When no read is asserted, `rd_data` is zero.
- R3: A program command (`cmd_op`=0) to an idle bank stores `cmd_wdata` at the host address when that bank's `op_done` arrives. An erase command (`cmd_op`=1) sets every word of the addressed sector to all ones when its `op_done` arrives. Words outside the target are left unchanged.
- R4: A read to a busy bank returns a status word. Bit 7 is the inverse of bit 7 of the program data, or 0 for an erase. Bit 6 is the bank's toggle bit, which inverts after every read cycle that hits the busy bank. All other bits are 0.
- R5: When `op_done` arrives for a busy bank, that bank leaves the busy state on the next edge and serves array reads again without any command.
- R6: Suspend (`cmd_op`=2) halts a running erase and leaves the bank not busy. While the erase is suspended, reads and programs to other sectors of the same bank proceed normally. A read of the sector being erased returns status with bit 7 set and bit 6 frozen, and a program into that sector is refused. Resume (`cmd_op`=3) makes the bank busy with the erase again.
- R7: A program or erase aimed at a busy bank, or an erase aimed at a bank with a suspended erase, is ignored and sets `err_o`.
- R8: `err_o` stays set until reset.
- R9: `ready_o` is high exactly when neither bank is busy. It drops on the edge that accepts a program, erase or resume.
- R10: While `lock_boot` is high, program and erase into the boot bank are refused with `err_o`, unless `acc_hv` is high. `bypass_o` equals `bypass_req` OR `acc_hv`.
- R11: After reset every array word is all ones, `ready_o` is 1 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | AW | Word address for reads and commands |
| host_ce | input | 1 | Chip enable, active high |
| host_we | input | 1 | Write enable, active high |
| host_oe | input | 1 | Output enable, active high |
| rd_data | output | DW | Array data or status word during a read |
| cmd_go | input | 1 | One-cycle strobe: a decoded command is accepted |
| cmd_op | input | 2 | 0 program, 1 erase sector, 2 suspend, 3 resume |
| cmd_wdata | input | DW | Program data |
| op_done | input | 2 | Per-bank completion strobe from the operation timer |
| lock_boot | input | 1 | Protects the boot bank from program and erase |
| acc_hv | input | 1 | High-voltage accelerate level: forces bypass, lifts the lock |
| bypass_req | input | 1 | Two-cycle program mode requested by the command layer |
| bypass_o | output | 1 | Two-cycle program mode in effect |
| ready_o | output | 1 | High when no bank is busy |
| err_o | output | 1 | Sticky flag for refused commands |

## Verification
The bench reads a busy bank and the idle bank in consecutive cycles. A design that stalled or shared one busy flag would return status from the idle bank. It aims reads and programs at both the suspended sector and its neighbours. A design that fenced the whole bank would corrupt a neighbour, and one that fenced nothing would let a program into the erasing sector. It probes both sides of the bank boundary (words 47 and 48) and erases a small boot sector between programmed words, to catch an off-by-one in the bank field or the wrong sector size. It also repeats status reads to catch a toggle bit that never inverts or keeps inverting after suspend.

// File: rtl/rww_pkg.sv
package rww_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_SUSP   = 2'd2,
    OP_RESUME = 2'd3
  } rww_op_e;
endpackage

// File: rtl/rww_decode.sv
// Address to bank and sector-base decode.
module rww_decode #(
  parameter int AW          = 6,
  parameter int BANK_BITS   = 2,
  parameter int SMALL_WORDS = 4,
  parameter int LARGE_WORDS = 16
) (
  input  logic [AW-1:0] addr,
  output logic          boot,
  output logic [AW-1:0] base
);
  localparam int SMALL_LG = $clog2(SMALL_WORDS);
  localparam int LARGE_LG = $clog2(LARGE_WORDS);

  always_comb begin
    boot = &addr[AW-1 -: BANK_BITS];
    if (boot) base = (addr >> SMALL_LG) << SMALL_LG;
    else      base = (addr >> LARGE_LG) << LARGE_LG;
  end
endmodule

// File: rtl/rww_bank_ctl.sv
// State of one bank: embedded operation, erase suspend, status toggle.
module rww_bank_ctl
  import rww_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_go,
  input  rww_op_e       op,
  input  logic [AW-1:0] haddr,
  input  logic [AW-1:0] hbase,
  input  logic [DW-1:0] wdata,
  input  logic          locked,
  input  logic          done,
  input  logic          rd_hit,
  output logic          busy_o,
  output logic          erasing_o,
  output logic          susp_o,
  output logic [AW-1:0] ebase_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pdata_o,
  output logic          tog_o,
  output logic          commit_prog_o,
  output logic          commit_erase_o,
  output logic          reject_o
);
  logic ok_prog, ok_erase;

  always_comb begin
    ok_prog  = !busy_o && !locked && !(susp_o && hbase == ebase_o);
    ok_erase = !busy_o && !susp_o && !locked;
    reject_o = sel_go && ((op == OP_PROG && !ok_prog) || (op == OP_ERASE && !ok_erase));
    commit_prog_o  = done && busy_o && !erasing_o;
    commit_erase_o = done && busy_o &&  erasing_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o    <= 1'b0;
      erasing_o <= 1'b0;
      susp_o    <= 1'b0;
      ebase_o   <= '0;
      paddr_o   <= '0;
      pdata_o   <= '0;
      tog_o     <= 1'b0;
    end else begin
      if (rd_hit && busy_o) tog_o <= ~tog_o;
      if (done && busy_o) begin
        busy_o <= 1'b0;
      end else if (sel_go) begin
        unique case (op)
          OP_PROG: if (ok_prog) begin
            busy_o    <= 1'b1;
            erasing_o <= 1'b0;
            paddr_o   <= haddr;
            pdata_o   <= wdata;
          end
          OP_ERASE: if (ok_erase) begin
            busy_o    <= 1'b1;
            erasing_o <= 1'b1;
            ebase_o   <= hbase;
          end
          OP_SUSP: if (busy_o && erasing_o) begin
            busy_o <= 1'b0;
            susp_o <= 1'b1;
          end
          OP_RESUME: if (susp_o && !busy_o) begin
            busy_o    <= 1'b1;
            erasing_o <= 1'b1;
            susp_o    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rww_array.sv
// Word array with one commit port per bank; erase clears a whole sector.
module rww_array #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int BANK_BITS   = 2,
  parameter int SMALL_WORDS = 4,
  parameter int LARGE_WORDS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       raddr,
  output logic [DW-1:0]       rdata,
  input  logic [1:0]          wr_en,
  input  logic [1:0][AW-1:0]  wr_addr,
  input  logic [1:0][DW-1:0]  wr_data,
  input  logic [1:0]          er_en,
  input  logic [1:0][AW-1:0]  er_base
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          w_boot [DEPTH];
  logic [AW-1:0] w_base [DEPTH];
  logic          w_bank [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    rww_decode #(
      .AW(AW), .BANK_BITS(BANK_BITS),
      .SMALL_WORDS(SMALL_WORDS), .LARGE_WORDS(LARGE_WORDS)
    ) u_dec (
      .addr (AW'(g)),
      .boot (w_boot[g]),
      .base (w_base[g])
    );
    assign w_bank[g] = ~w_boot[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (er_en[w_bank[i]] && er_base[w_bank[i]] == w_base[i]) mem[i] <= '1;
        if (wr_en[w_bank[i]] && wr_addr[w_bank[i]] == AW'(i)) mem[i] <= wr_data[w_bank[i]];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rww_ctrl.sv
// Top: two bank controllers, shared array, read steering.
module rww_ctrl
  import rww_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int BANK_BITS   = 2,
  parameter int SMALL_WORDS = 4,
  parameter int LARGE_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_ce,
  input  logic          host_we,
  input  logic          host_oe,
  output logic [DW-1:0] rd_data,
  input  logic          cmd_go,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [1:0]    op_done,
  input  logic          lock_boot,
  input  logic          acc_hv,
  input  logic          bypass_req,
  output logic          bypass_o,
  output logic          ready_o,
  output logic          err_o
);
  logic                hboot, hbank, rd_strobe;
  logic [AW-1:0]       hbase;
  logic [1:0]          busy, erasing, susp, tog, cprog, cerase, rej;
  logic [1:0][AW-1:0]  ebase, paddr;
  logic [1:0][DW-1:0]  pdata;
  logic [DW-1:0]       arr_rdata;

  rww_decode #(
    .AW(AW), .BANK_BITS(BANK_BITS),
    .SMALL_WORDS(SMALL_WORDS), .LARGE_WORDS(LARGE_WORDS)
  ) u_hdec (
    .addr (host_addr),
    .boot (hboot),
    .base (hbase)
  );

  assign hbank     = ~hboot;
  assign rd_strobe = host_ce & host_oe & ~host_we;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rww_bank_ctl #(.AW(AW), .DW(DW)) u_bank (
      .clk            (clk),
      .rst_n          (rst_n),
      .sel_go         (cmd_go && (hbank == 1'(b))),
      .op             (rww_op_e'(cmd_op)),
      .haddr          (host_addr),
      .hbase          (hbase),
      .wdata          (cmd_wdata),
      .locked         ((b == 0) ? (lock_boot & ~acc_hv) : 1'b0),
      .done           (op_done[b]),
      .rd_hit         (rd_strobe && (hbank == 1'(b))),
      .busy_o         (busy[b]),
      .erasing_o      (erasing[b]),
      .susp_o         (susp[b]),
      .ebase_o        (ebase[b]),
      .paddr_o        (paddr[b]),
      .pdata_o        (pdata[b]),
      .tog_o          (tog[b]),
      .commit_prog_o  (cprog[b]),
      .commit_erase_o (cerase[b]),
      .reject_o       (rej[b])
    );
  end

  rww_array #(
    .AW(AW), .DW(DW), .BANK_BITS(BANK_BITS),
    .SMALL_WORDS(SMALL_WORDS), .LARGE_WORDS(LARGE_WORDS)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr   (host_addr),
    .rdata   (arr_rdata),
    .wr_en   (cprog),
    .wr_addr (paddr),
    .wr_data (pdata),
    .er_en   (cerase),
    .er_base (ebase)
  );

  always_comb begin
    rd_data = '0;
    if (rd_strobe) begin
      if (busy[hbank]) begin
        rd_data[7] = erasing[hbank] ? 1'b0 : ~pdata[hbank][7];
        rd_data[6] = tog[hbank];
      end else if (susp[hbank] && hbase == ebase[hbank]) begin
        rd_data[7] = 1'b1;
        rd_data[6] = tog[hbank];
      end else begin
        rd_data = arr_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_o <= 1'b0;
    else if (|rej) err_o <= 1'b1;
  end

  assign ready_o  = ~|busy;
  assign bypass_o = bypass_req | acc_hv;
endmodule

// File: rtl/rww_ctrl_chk.sv
module rww_ctrl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_go,
  input logic [1:0]    cmd_op,
  input logic          hbank,
  input logic [1:0]    busy,
  input logic          rd_strobe,
  input logic [AW-1:0] host_addr,
  input logic          rd_b6,
  input logic [1:0]    op_done,
  input logic          ready_o,
  input logic          err_o
);
  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $past(cmd_go)); // R9
  AST_AUTO_RETURN_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done[0] && busy[0]) |=> !busy[0]); // R5
  AST_AUTO_RETURN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done[1] && busy[1]) |=> !busy[1]); // R5
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !cmd_op[1] && busy[hbank]) |=> err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8
  AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy[hbank] && $past(rd_strobe && busy[hbank]) && $stable(host_addr))
      |-> (rd_b6 != $past(rd_b6))); // R4
endmodule

bind rww_ctrl rww_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_go    (cmd_go),
  .cmd_op    (cmd_op),
  .hbank     (hbank),
  .busy      (busy),
  .rd_strobe (rd_strobe),
  .host_addr (host_addr),
  .rd_b6     (rd_data[6]),
  .op_done   (op_done),
  .ready_o   (ready_o),
  .err_o     (err_o)
);

// File: tb/tb_rww_ctrl.sv
`timescale 1ns/1ps
module tb_rww_ctrl;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] host_addr;
  logic          host_ce, host_we, host_oe;
  logic [DW-1:0] rd_data;
  logic          cmd_go;
  logic [1:0]    cmd_op;
  logic [DW-1:0] cmd_wdata;
  logic [1:0]    op_done;
  logic          lock_boot, acc_hv, bypass_req;
  logic          bypass_o, ready_o, err_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  logic tog [2];

  always #5 clk = ~clk;

  rww_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_ce(host_ce),
    .host_we(host_we), .host_oe(host_oe), .rd_data(rd_data), .cmd_go(cmd_go),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .op_done(op_done),
    .lock_boot(lock_boot), .acc_hv(acc_hv), .bypass_req(bypass_req),
    .bypass_o(bypass_o), .ready_o(ready_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_bus();
    host_ce = 0; host_we = 0; host_oe = 0;
    cmd_go = 0; cmd_op = 0; cmd_wdata = '0; op_done = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; clear_bus(); host_addr = '0;
    lock_boot = 0; acc_hv = 0; bypass_req = 0;
    tog[0] = 0; tog[1] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle();
    @(negedge clk); clear_bus();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    clear_bus();
    host_addr = a; host_ce = 1; host_we = 1;
    cmd_go = 1; cmd_op = op; cmd_wdata = d;
    @(negedge clk); clear_bus();
  endtask

  task automatic finish_op(input int b);
    @(negedge clk);
    clear_bus(); op_done[b] = 1'b1;
    @(negedge clk); clear_bus();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    clear_bus();
    host_addr = a; host_ce = 1; host_oe = 1;
    #1 chk(tag, rd_data, exp);
  endtask

  // read of a busy bank: status word, then toggle inverts at the edge
  task automatic rd_busy(input logic [AW-1:0] a, input int b, input logic b7, input string tag);
    rd(a, {8'h00, b7, tog[b], 6'h00}, tag);
    tog[b] = ~tog[b];
  endtask

  // read of the suspended sector: bit 7 set, toggle frozen
  task automatic rd_fence(input logic [AW-1:0] a, input int b, input string tag);
    rd(a, {8'h00, 1'b1, tog[b], 6'h00}, tag);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R11 ready after reset", 16'(ready_o), 16'h1);
    chk("R11 err after reset", 16'(err_o), 16'h0);
    rd(6'd0, 16'hFFFF, "R11 word 0 erased");
    rd(6'd63, 16'hFFFF, "R11 word 63 erased");
    idle(); #1;
    chk("R2 rd_data zero without read", rd_data, 16'h0000);
  endtask

  task automatic t_read_while_write();
    do_reset();
    cmd(2'd0, 6'd5, 16'h1234);
    chk("R9 ready low after program", 16'(ready_o), 16'h0);
    rd_busy(6'd5, 1, 1'b1, "R4 status first read");
    rd_busy(6'd5, 1, 1'b1, "R4 status toggled");
    rd(6'd50, 16'hFFFF, "R2 idle boot bank zero latency");
    rd_busy(6'd5, 1, 1'b1, "R4 status after other bank read");
    idle();
    finish_op(1);
    chk("R5 ready after done", 16'(ready_o), 16'h1);
    rd(6'd5, 16'h1234, "R3 programmed word");
    rd(6'd4, 16'hFFFF, "R3 neighbour untouched");
    idle();
  endtask

  task automatic t_busy_reject();
    do_reset();
    cmd(2'd0, 6'd20, 16'h00F0);
    cmd(2'd0, 6'd21, 16'h0000);
    chk("R7 err after program to busy bank", 16'(err_o), 16'h1);
    chk("R7 ready still low", 16'(ready_o), 16'h0);
    finish_op(1);
    rd(6'd21, 16'hFFFF, "R7 refused program left no data");
    rd(6'd20, 16'h00F0, "R3 first program stored");
    idle(); idle(); idle();
    chk("R8 err stays set", 16'(err_o), 16'h1);
  endtask

  task automatic t_both_busy();
    do_reset();
    cmd(2'd0, 6'd10, 16'hAAAA);
    cmd(2'd0, 6'd55, 16'h0F0F);
    chk("R9 ready low both busy", 16'(ready_o), 16'h0);
    rd_busy(6'd10, 1, 1'b0, "R4 main status bit7 clear");
    rd_busy(6'd55, 0, 1'b1, "R4 boot status bit7 set");
    idle();
    finish_op(0);
    chk("R9 ready low while main busy", 16'(ready_o), 16'h0);
    rd(6'd55, 16'h0F0F, "R5 boot bank back to array");
    idle();
    finish_op(1);
    chk("R9 ready high both done", 16'(ready_o), 16'h1);
    rd(6'd10, 16'hAAAA, "R3 main word stored");
    idle();
  endtask

  task automatic t_decode();
    do_reset();
    cmd(2'd0, 6'd10, 16'h1111);
    rd_busy(6'd47, 1, 1'b1, "R1 word 47 in main bank");
    rd(6'd48, 16'hFFFF, "R1 word 48 in boot bank");
    idle();
    finish_op(1);
    cmd(2'd0, 6'd48, 16'h0001); finish_op(0);
    cmd(2'd0, 6'd51, 16'h0002); finish_op(0);
    cmd(2'd0, 6'd52, 16'h0003); finish_op(0);
    cmd(2'd1, 6'd49, 16'h0000);
    rd_busy(6'd50, 0, 1'b0, "R4 erase status");
    idle();
    finish_op(0);
    rd(6'd48, 16'hFFFF, "R1 boot sector erased low");
    rd(6'd51, 16'hFFFF, "R1 boot sector erased high");
    rd(6'd52, 16'h0003, "R1 next boot sector kept");
    idle();
    cmd(2'd0, 6'd17, 16'h1717); finish_op(1);
    cmd(2'd0, 6'd33, 16'h3333); finish_op(1);
    cmd(2'd1, 6'd31, 16'h0000); finish_op(1);
    rd(6'd17, 16'hFFFF, "R3 main sector erased");
    rd(6'd33, 16'h3333, "R3 other main sector kept");
    idle();
  endtask

  task automatic t_suspend();
    do_reset();
    cmd(2'd0, 6'd18, 16'h00AA); finish_op(1);
    cmd(2'd1, 6'd16, 16'h0000);
    chk("R9 ready low during erase", 16'(ready_o), 16'h0);
    cmd(2'd2, 6'd16, 16'h0000);
    chk("R6 ready high after suspend", 16'(ready_o), 16'h1);
    rd_fence(6'd18, 1, "R6 fenced sector status");
    rd_fence(6'd19, 1, "R6 fenced toggle frozen");
    rd(6'd2, 16'hFFFF, "R6 same bank other sector readable");
    idle();
    cmd(2'd0, 6'd2, 16'h5555);
    chk("R6 program in suspend accepted", 16'(ready_o), 16'h0);
    rd_busy(6'd2, 1, 1'b1, "R6 status during suspend program");
    idle();
    finish_op(1);
    chk("R6 ready after suspend program", 16'(ready_o), 16'h1);
    rd(6'd2, 16'h5555, "R6 suspend program stored");
    idle();
    chk("R6 no error so far", 16'(err_o), 16'h0);
    cmd(2'd0, 6'd19, 16'h0000);
    chk("R6 program to erasing sector refused", 16'(err_o), 16'h1);
    cmd(2'd3, 6'd16, 16'h0000);
    chk("R6 resume makes bank busy", 16'(ready_o), 16'h0);
    rd_busy(6'd18, 1, 1'b0, "R6 erase status after resume");
    idle();
    finish_op(1);
    rd(6'd18, 16'hFFFF, "R6 erase completed");
    rd(6'd19, 16'hFFFF, "R6 refused program left no data");
    rd(6'd2, 16'h5555, "R6 other sector kept");
    idle();
  endtask

  task automatic t_lock();
    do_reset();
    lock_boot = 1;
    cmd(2'd0, 6'd52, 16'h1234);
    chk("R10 locked boot program refused", 16'(err_o), 16'h1);
    chk("R10 ready stays high", 16'(ready_o), 16'h1);
    rd(6'd52, 16'hFFFF, "R10 locked word unchanged");
    idle();
    cmd(2'd0, 6'd5, 16'h0707);
    chk("R10 main bank not locked", 16'(ready_o), 16'h0);
    finish_op(1);
    do_reset();
    lock_boot = 1; acc_hv = 1;
    #1 chk("R10 accelerate forces bypass", 16'(bypass_o), 16'h1);
    cmd(2'd0, 6'd52, 16'h4321);
    chk("R10 accelerate lifts lock", 16'(ready_o), 16'h0);
    finish_op(0);
    rd(6'd52, 16'h4321, "R10 program under accelerate");
    idle();
    chk("R10 no error under accelerate", 16'(err_o), 16'h0);
    acc_hv = 0; bypass_req = 1;
    #1 chk("R10 bypass request", 16'(bypass_o), 16'h1);
    bypass_req = 0;
    #1 chk("R10 bypass off", 16'(bypass_o), 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    host_addr = '0;
    clear_bus();
    lock_boot = 0; acc_hv = 0; bypass_req = 0;
    t_reset();
    t_read_while_write();
    t_busy_reject();
    t_both_busy();
    t_decode();
    t_suspend();
    t_lock();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule